// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block is the transmit side of a serial audio port that owns its clocks. It divides the system clock down to a bit clock and counts bit clocks to produce a frame sync. Within each frame it shifts PCM words out, most significant bit first. A single frame engine covers I2S, left-justified and the two DSP framings. The configuration chooses the sync width, the data delay after the sync edge, single-phase or dual-phase stereo framing, the word length and the polarity of both the clock and the sync.

Software loads the configuration while the port is disabled and then raises the enable. The port checks that the frame can hold all the words it must carry. If it cannot, the port raises an error flag and stays idle. Otherwise it begins at bit 0 of a frame and takes samples from a valid/ready stream, one word at the start of each word slot. If no sample is offered when a slot begins, the port sends zeros and raises an underrun flag. Both flags clear when the port is disabled.

Top module: `pcm_serial_tx`

## Requirements
- R1: One bit period lasts `cfg_div`+1 clock cycles. While running, the bit clock is low for the first ((`cfg_div`+1)>>1) cycles of each bit period and high for the rest, before polarity inversion. The first cycle of a bit period is the falling edge, where data and sync change.
- R2: A frame is `cfg_fper`+1 bit periods long. After the last bit of a frame the bit index returns to 0.
- R3: The frame sync is active on bits 0 to `cfg_fwid` of every frame. Half a frame gives I2S or left-justified timing; `cfg_fwid`=0 gives a one-bit DSP pulse.
- R4: The first word begins `cfg_delay1` bit periods after frame start: 1 for I2S and DSP-A, 0 for left-justified and DSP-B.
- R5: With `cfg_dual`=1 the frame has two phases of one word each, and the second word begins at bit `cfg_fwid`+1+`cfg_delay1`. With `cfg_dual`=0 the words follow each other without gaps, `cfg_chan`+1 of them. A word is 16 bits (`cfg_wlen32`=0, taken from `s_data[15:0]`) or 32 bits (`cfg_wlen32`=1) and is sent MSB first. Bits outside a word are 0.
- R6: `s_ready` is high exactly in the cycle just before the first bit of a word slot. A word is taken in that cycle.
- R7: When the port is enabled, if `cfg_div`=0 or if `cfg_fper`+1 is less than the word length times the word count, `cfg_err` rises and no clock is produced. `cfg_err` stays high until `en` falls.
- R8: A slot that starts without `s_valid` carries all zeros and sets `underrun`. `underrun` stays set until `en` falls.
- R9: `cfg_clk_inv` inverts the bit clock pin and `cfg_fs_inv` inverts the frame sync pin, each independently. Both apply to the idle levels as well.
- R10: Configuration is captured only while `en` is low. Changes made while enabled have no effect. Enabling starts at bit 0 of a frame.
- R11: A synchronous reset drives the bit clock, frame sync, serial data and both flags low.
- R12: When `en` falls, the pins go to their idle levels one clock later: the clock and sync at their inversion levels, and data low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the source of the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable; configuration is latched while low |
| cfg_div | input | 8 | Bit clock divide ratio minus one |
| cfg_fper | input | 12 | Frame length in bit clocks minus one |
| cfg_fwid | input | 8 | Frame sync active width in bit clocks minus one |
| cfg_wlen32 | input | 1 | Word length: 0 is 16 bits, 1 is 32 bits |
| cfg_delay1 | input | 1 | Data delay after the sync edge: 0 or 1 bit |
| cfg_dual | input | 1 | Dual-phase framing, one word per phase |
| cfg_chan | input | 3 | Words per single-phase frame minus one |
| cfg_clk_inv | input | 1 | Invert the bit clock pin |
| cfg_fs_inv | input | 1 | Invert the frame sync pin |
| s_valid | input | 1 | A sample word is offered |
| s_data | input | 32 | Sample word, right-aligned for 16-bit length |
| s_ready | output | 1 | Word taken in this cycle |
| bclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame sync |
| sd_o | output | 1 | Serial data |
| cfg_err | output | 1 | Configuration rejected |
| underrun | output | 1 | A slot started with no sample offered |

## Verification
The bench uses the default field widths: an 8-bit divider, a 12-bit frame period, a 3-bit channel field and 32-bit sample words. It programs divide ratios of 2 to 4 and frames of 32 to 80 bit clocks, so every scenario runs through several complete frames, several frame wraps and many slot boundaries in a short run. These settings cover all four framings, both word lengths, single-phase frames with two and four words, both inversions, a frame one bit too short for its words, a zero divider, and a disable in the middle of a bit period.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  localparam int DIV_W  = 8;
  localparam int PER_W  = 12;
  localparam int WID_W  = 8;
  localparam int CH_W   = 3;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 5;

  typedef struct packed {
    logic [PER_W-1:0] fper;
    logic [WID_W-1:0] fwid;
    logic             wlen32;
    logic             delay1;
    logic             dual;
    logic [CH_W-1:0]  chan;
  } frm_t;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             clk_inv;
    logic             fs_inv;
    frm_t             frm;
  } cfg_t;

  typedef struct packed {
    logic             act;
    logic [OFF_W-1:0] off;
  } slot_t;

  // Position of frame bit b inside the word slots of the frame.
  function automatic slot_t locate(logic [PER_W-1:0] b, frm_t f);
    logic [PER_W:0] bb, d, s1, rel, k, wl;
    slot_t s;
    bb = {1'b0, b};
    d  = (PER_W+1)'(f.delay1);
    s1 = (PER_W+1)'(f.fwid) + (PER_W+1)'(1) + d;
    wl = f.wlen32 ? (PER_W+1)'(32) : (PER_W+1)'(16);
    k  = '0;
    if (f.dual) begin
      rel   = (bb >= s1) ? (bb - s1) : (bb - d);
      s.act = (bb >= d) && (rel < wl);
    end else begin
      rel   = bb - d;
      k     = f.wlen32 ? (rel >> 5) : (rel >> 4);
      s.act = (bb >= d) && (k <= (PER_W+1)'(f.chan));
    end
    s.off = f.wlen32 ? rel[4:0] : {1'b0, rel[3:0]};
    return s;
  endfunction

  // The frame must hold every word it carries, and the divider must be at least 2.
  function automatic logic frame_ok(cfg_t c);
    logic [PER_W:0] fsz, n, need;
    fsz  = {1'b0, c.frm.fper} + (PER_W+1)'(1);
    n    = c.frm.dual ? (PER_W+1)'(2) : ((PER_W+1)'(c.frm.chan) + (PER_W+1)'(1));
    need = c.frm.wlen32 ? (n << 5) : (n << 4);
    return (c.div != '0) && (fsz >= need);
  endfunction
endpackage

// File: rtl/pcm_tx_bitclk.sv
module pcm_tx_bitclk
  import pcm_tx_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          start,
  input  logic [DW-1:0] div,
  output logic          tick,
  output logic          hi
);
  logic [DW-1:0] cnt;
  logic [DW:0]   half;

  assign half = ({1'b0, div} + {{DW{1'b0}}, 1'b1}) >> 1;
  assign tick = run && (cnt == div);
  assign hi   = ({1'b0, cnt} >= half);

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (start) cnt <= '0;
    else if (run)   cnt <= tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/pcm_tx_framer.sv
module pcm_tx_framer
  import pcm_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             adv,
  input  frm_t             frm,
  output logic             fs_act,
  output logic             cur_act,
  output logic [OFF_W-1:0] cur_off,
  output logic             load_slot
);
  logic [PER_W-1:0] bitn, nb;
  slot_t            cur, nxt;

  always_comb begin
    if (start)                nb = '0;
    else if (bitn == frm.fper) nb = '0;
    else                      nb = bitn + 1'b1;
  end

  assign cur       = locate(bitn, frm);
  assign nxt       = locate(nb, frm);
  assign cur_act   = cur.act;
  assign cur_off   = cur.off;
  assign load_slot = nxt.act && (nxt.off == '0);
  assign fs_act    = (bitn <= PER_W'(frm.fwid));

  always_ff @(posedge clk) begin
    if (rst)               bitn <= '0;
    else if (start || adv) bitn <= nb;
  end
endmodule

// File: rtl/pcm_tx_word.sv
module pcm_tx_word
  import pcm_tx_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic         valid,
  input  logic [W-1:0] data,
  output logic [W-1:0] word_q,
  output logic         urun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      urun   <= 1'b0;
    end else begin
      if (load) word_q <= valid ? data : '0;
      if (clr)                urun <= 1'b0;
      else if (load && !valid) urun <= 1'b1;
    end
  end
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
  import pcm_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [PER_W-1:0]  cfg_fper,
  input  logic [WID_W-1:0]  cfg_fwid,
  input  logic              cfg_wlen32,
  input  logic              cfg_delay1,
  input  logic              cfg_dual,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic              cfg_clk_inv,
  input  logic              cfg_fs_inv,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              bclk_o,
  output logic              fs_o,
  output logic              sd_o,
  output logic              cfg_err,
  output logic              underrun
);
  cfg_t              cfg_in, cfg_q;
  logic              run_q, err_q, run_go, start, ok;
  logic              tick, hi, fs_act, cur_act, load_slot, load;
  logic [OFF_W-1:0]  cur_off, idx;
  logic [DATA_W-1:0] word_q;
  logic              sd_bit;

  assign cfg_in.div        = cfg_div;
  assign cfg_in.clk_inv    = cfg_clk_inv;
  assign cfg_in.fs_inv     = cfg_fs_inv;
  assign cfg_in.frm.fper   = cfg_fper;
  assign cfg_in.frm.fwid   = cfg_fwid;
  assign cfg_in.frm.wlen32 = cfg_wlen32;
  assign cfg_in.frm.delay1 = cfg_delay1;
  assign cfg_in.frm.dual   = cfg_dual;
  assign cfg_in.frm.chan   = cfg_chan;

  assign ok     = frame_ok(cfg_q);
  assign run_go = run_q && en;
  assign start  = en && !run_q && !err_q && ok;
  assign load   = (start || tick) && load_slot;
  assign s_ready = load;

  pcm_tx_bitclk u_bitclk (
    .clk(clk), .rst(rst), .run(run_go), .start(start),
    .div(cfg_q.div), .tick(tick), .hi(hi)
  );

  pcm_tx_framer u_framer (
    .clk(clk), .rst(rst), .start(start), .adv(tick), .frm(cfg_q.frm),
    .fs_act(fs_act), .cur_act(cur_act), .cur_off(cur_off), .load_slot(load_slot)
  );

  pcm_tx_word u_word (
    .clk(clk), .rst(rst), .clr(!en), .load(load), .valid(s_valid),
    .data(s_data), .word_q(word_q), .urun(underrun)
  );

  assign idx    = (cfg_q.frm.wlen32 ? 5'd31 : 5'd15) - cur_off;
  assign sd_bit = cur_act && word_q[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      run_q  <= 1'b0;
      err_q  <= 1'b0;
      bclk_o <= 1'b0;
      fs_o   <= 1'b0;
      sd_o   <= 1'b0;
    end else begin
      if (!en) begin
        cfg_q <= cfg_in;
        run_q <= 1'b0;
        err_q <= 1'b0;
      end else if (!run_q && !err_q) begin
        if (ok) run_q <= 1'b1;
        else    err_q <= 1'b1;
      end
      if (run_q) begin
        bclk_o <= hi ^ cfg_q.clk_inv;
        fs_o   <= fs_act ^ cfg_q.fs_inv;
        sd_o   <= sd_bit;
      end else begin
        bclk_o <= cfg_q.clk_inv;
        fs_o   <= cfg_q.fs_inv;
        sd_o   <= 1'b0;
      end
    end
  end

  assign cfg_err = err_q;
endmodule

// File: rtl/pcm_tx_chk.sv
module pcm_tx_chk
  import pcm_tx_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic               s_ready,
  input logic               bclk_o,
  input logic               sd_o,
  input logic               cfg_err,
  input logic               underrun,
  input logic               run_q,
  input logic [$bits(cfg_t)-1:0] cfg_bits
);
  // R7: a rejected configuration produces no clock edges
  p_err_freezes_clock_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_err && en |=> $stable(bclk_o));

  // R12: an idle port drives its data line low
  p_idle_sd_low_r12: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> !sd_o);

  // R8: the underrun flag holds while enabled
  p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    underrun && en |=> underrun);

  // R6: a word taken at start means the port is running next cycle
  p_start_runs_r6: assert property (@(posedge clk) disable iff (rst)
    s_ready && !run_q |=> run_q);

  // R10: configuration does not move while running
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    run_q && en |=> $stable(cfg_bits));
endmodule

bind pcm_serial_tx pcm_tx_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .s_ready(s_ready), .bclk_o(bclk_o),
  .sd_o(sd_o), .cfg_err(cfg_err), .underrun(underrun), .run_q(run_q),
  .cfg_bits(cfg_q)
);

// File: tb/pcm_serial_tx_bench.sv
module pcm_serial_tx_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1, en = 0;
  logic [7:0]  cfg_div = 0;
  logic [11:0] cfg_fper = 0;
  logic [7:0]  cfg_fwid = 0;
  logic        cfg_wlen32 = 0, cfg_delay1 = 0, cfg_dual = 0;
  logic [2:0]  cfg_chan = 0;
  logic        cfg_clk_inv = 0, cfg_fs_inv = 0;
  logic        s_valid = 0;
  logic [31:0] s_data = 32'h9E37_79B9;
  logic        s_ready, bclk_o, fs_o, sd_o, cfg_err, underrun;

  int vecs = 0, bad = 0;

  // reference model state
  int m_div, m_fper, m_fwid, m_w32, m_d1, m_dual, m_chan, m_ci, m_fi;
  int m_run, m_err, m_urun, m_cnt, m_bit;
  logic [31:0] m_word;
  logic mp_b, mp_f, mp_s;
  bit adv_pending;

  pcm_serial_tx u_pcm_serial_tx (
    .clk(clk), .rst(rst), .en(en), .cfg_div(cfg_div), .cfg_fper(cfg_fper),
    .cfg_fwid(cfg_fwid), .cfg_wlen32(cfg_wlen32), .cfg_delay1(cfg_delay1),
    .cfg_dual(cfg_dual), .cfg_chan(cfg_chan), .cfg_clk_inv(cfg_clk_inv),
    .cfg_fs_inv(cfg_fs_inv), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .bclk_o(bclk_o), .fs_o(fs_o), .sd_o(sd_o),
    .cfg_err(cfg_err), .underrun(underrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int wlen();
    return (m_w32 != 0) ? 32 : 16;
  endfunction

  function automatic void m_loc(int b, output bit act, output int off);
    int rel, s1;
    s1 = m_fwid + 1 + m_d1;
    if (m_dual != 0) begin
      rel = (b >= s1) ? b - s1 : b - m_d1;
      act = (b >= m_d1) && (rel < wlen());
    end else begin
      rel = b - m_d1;
      act = (b >= m_d1) && ((rel / wlen()) <= m_chan);
    end
    off = (rel < 0) ? 0 : rel % wlen();
  endfunction

  function automatic bit m_ok();
    int n;
    n = (m_dual != 0) ? 2 : m_chan + 1;
    return (m_div != 0) && (m_fper + 1 >= wlen() * n);
  endfunction

  function automatic bit slot_start(int b);
    bit a; int o;
    m_loc(b, a, o);
    return a && (o == 0);
  endfunction

  function automatic bit m_ready();
    int nb;
    if (!en) return 0;
    if (m_run == 0) return (m_err == 0) && m_ok() && slot_start(0);
    if (m_cnt != m_div) return 0;
    nb = (m_bit == m_fper) ? 0 : m_bit + 1;
    return slot_start(nb);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_load();
    if (s_valid) begin
      m_word = s_data;
      adv_pending = 1;
    end else begin
      m_word = '0;
      m_urun = 1;
    end
  endtask

  task automatic m_update();
    logic pb, pf, ps; bit a; int o; bit rdy;
    if (rst) begin
      {m_div, m_fper, m_fwid, m_w32, m_d1, m_dual, m_chan, m_ci, m_fi} = '{default:0};
      m_run = 0; m_err = 0; m_urun = 0; m_cnt = 0; m_bit = 0; m_word = '0;
      mp_b = 0; mp_f = 0; mp_s = 0;
      return;
    end
    if (m_run != 0) begin
      pb = (m_cnt >= (m_div + 1) / 2) ^ m_ci[0];
      pf = (m_bit <= m_fwid) ^ m_fi[0];
      m_loc(m_bit, a, o);
      ps = a ? m_word[wlen() - 1 - o] : 1'b0;
    end else begin
      pb = m_ci[0]; pf = m_fi[0]; ps = 0;
    end
    rdy = m_ready();
    if (!en) begin
      m_run = 0; m_err = 0; m_urun = 0;
      m_div = cfg_div; m_fper = cfg_fper; m_fwid = cfg_fwid; m_w32 = cfg_wlen32;
      m_d1 = cfg_delay1; m_dual = cfg_dual; m_chan = cfg_chan;
      m_ci = cfg_clk_inv; m_fi = cfg_fs_inv;
    end else if (m_run == 0) begin
      if (m_err == 0) begin
        if (m_ok()) begin
          m_run = 1; m_cnt = 0; m_bit = 0;
          if (rdy) m_load();
        end else m_err = 1;
      end
    end else if (m_cnt == m_div) begin
      m_cnt = 0;
      m_bit = (m_bit == m_fper) ? 0 : m_bit + 1;
      if (rdy) m_load();
    end else m_cnt++;
    mp_b = pb; mp_f = pf; mp_s = ps;
  endtask

  // one clock: compare at settle time, advance the model at the edge
  task automatic cycle();
    #1;
    vecs++;
    chk("R6 R10 ready", s_ready, m_ready());
    chk("R1 R9 R12 bclk", bclk_o, mp_b);
    chk("R2 R3 R9 fs", fs_o, mp_f);
    chk("R4 R5 sd", sd_o, mp_s);
    chk("R7 cfg_err", cfg_err, m_err[0]);
    chk("R8 underrun", underrun, m_urun[0]);
    @(posedge clk);
    m_update();
    @(negedge clk);
    if (adv_pending) begin
      s_data = s_data * 32'd1664525 + 32'd1013904223;
      adv_pending = 0;
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic setc(int dv, int fp, int fw, int w32, int d1, int du, int ch, int ci, int fi);
    cfg_div = 8'(dv); cfg_fper = 12'(fp); cfg_fwid = 8'(fw); cfg_wlen32 = w32[0];
    cfg_delay1 = d1[0]; cfg_dual = du[0]; cfg_chan = 3'(ch);
    cfg_clk_inv = ci[0]; cfg_fs_inv = fi[0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    run(3);
    rst = 0;
    // R11: reset state at the pins
    #1;
    chk("R11 bclk", bclk_o, 1'b0); chk("R11 fs", fs_o, 1'b0); chk("R11 sd", sd_o, 1'b0);
    chk("R11 err", cfg_err, 1'b0); chk("R11 urun", underrun, 1'b0);
    // I2S-like: dual phase 16-bit, delay 1, half-frame sync
    setc(1, 31, 15, 0, 1, 1, 1, 0, 1);
    s_valid = 1;
    run(3);
    en = 1; run(100);
    // R10: changes while enabled are ignored
    setc(5, 200, 3, 1, 0, 0, 7, 1, 0);
    run(120);
    en = 0; run(4);
    // left-justified: 32-bit dual phase, delay 0, inverted clock
    setc(2, 63, 31, 1, 0, 1, 0, 1, 0);
    run(3); en = 1; run(450);
    en = 0; run(4);
    // DSP-A: single phase, 4 words of 16 bits, one-bit pulse
    setc(3, 79, 0, 0, 1, 0, 3, 0, 0);
    run(3); en = 1; run(700);
    en = 0; run(4);
    // DSP-B with underrun, then stop in mid bit (R8, R12)
    setc(1, 39, 0, 0, 0, 0, 1, 0, 1);
    s_valid = 0;
    run(3); en = 1; run(100);
    s_valid = 1; run(157);
    en = 0; run(6);
    // R7: frame one bit too short, then zero divider
    setc(1, 30, 15, 0, 1, 1, 1, 0, 0);
    run(3); en = 1; run(20);
    en = 0; run(4);
    setc(0, 31, 15, 0, 1, 1, 1, 1, 1);
    run(3); en = 1; run(20);
    en = 0; run(4);
    // recovery and 32-bit single-phase stereo with both inversions
    setc(1, 63, 0, 1, 1, 0, 1, 1, 1);
    run(3); en = 1; run(400);
    en = 0; run(5);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule